// File: doc/BRIEF.md
# Block Transfer Sequencer

This block carries out a multi-register memory transfer, one word per clock. A single start pulse supplies a register mask, a base address, the index of the base register and five control bits: direction (up or down), pre/post indexing, base writeback, load or store, and a privilege-override bit. The sequencer works through the set bits of the mask in rising register index. The lowest register always uses the lowest word address. For each set bit it reads the register file and writes memory (store), or it reads memory and writes the register file (load). It then finishes by updating the base register.

Register index 15 is the program counter. It is transferred last. On a store its word is the combined counter-and-status value. On a load with the override bit set, the loaded word also rewrites the status bits. An abort on a load undoes the load before it and discards the rest. An abort on a store lets the rest of the stores complete. In both cases, and when the start address is outside the 26-bit address space, the sequencer raises an exception pulse as it finishes. While the transfer runs, a separate output asks the register file to use the user bank.

Top module: `lsm_seq`

## Requirements
- R1: Set mask bits are transferred in ascending register index, one memory access per cycle, at consecutive word addresses that rise by 4.
- R2: For a down transfer the lowest access address is derived from the base minus 4×N, where N is the number of set bits. The final (writeback) address is base−4×N. For an up transfer it is base+4×N.
- R3: The access address is advanced before the access when pre equals up, and after it otherwise. So up+pre starts at base+4, up+post at base, down+pre at base−4N, and down+post at base−4N+4.
- R4: A stored copy of the base register holds the original base only when it is the first register transferred. With writeback set it holds the final address otherwise.
- R5: With writeback set, the base register receives the final address even when the mask is empty. A base index of 15 is never written back.
- R6: user_bank_o is high while a transfer is in progress for a store with S set, and for a load with S set whose mask lacks bit 15. It is low in all other cases.
- R7: On a load abort, the aborting load and the one before it leave their registers unchanged. Later loads are dropped. The base register ends at the final address (writeback) or the original base (no writeback).
- R8: On a store abort, every later store in the list is still issued, and exc_o rises when the transfer finishes.
- R9: A start address (after the down adjustment) at or above 2^26 suppresses every store request and raises exc_o at completion. Loads are still performed.
- R10: Index 15 is transferred last. A store of index 15 sends pc_status_i. A load of index 15 with S set also pulses psr_we_o with the same data.
- R11: In the cycle where done_o and exc_o are high, user_bank_o is already low.
- R12: After reset, or on reset mid-transfer, the block is idle: busy_o, done_o, mem_req_o, rf_we_o and user_bank_o are low.
- R13: done_o is high for one cycle, N+3 cycles after the clock edge that samples start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (sampled when idle) |
| mask_i | input | 16 | Register mask |
| base_idx_i | input | 4 | Base register index |
| base_addr_i | input | 32 | Base register value |
| up_i | input | 1 | 1: addresses above base, 0: below |
| pre_i | input | 1 | Pre-indexing select |
| wb_i | input | 1 | Write final address to base |
| load_i | input | 1 | 1: load, 0: store |
| s_i | input | 1 | Privilege-override bit |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| exc_o | output | 1 | Exception, valid with done_o |
| user_bank_o | output | 1 | Force user register bank |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, same cycle |
| mem_abort_i | input | 1 | Access aborted, same cycle |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data, same cycle |
| pc_status_i | input | 32 | Counter with status bits, stored for index 15 |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| psr_we_o | output | 1 | Status bits write enable |

## Verification
Memory accesses appear in the cycles 1 to N that follow the edge sampling start_i. Loaded data reaches the register file one access later, or in cycle N+1 for the last one. The base update lands in cycle N+2, and done_o with exc_o is due in cycle N+3. The bench drives start_i at a falling edge and counts falling edges until done_o. It compares that count with N+3 and samples user_bank_o in cycle 1. It compares the register, memory and status images only at the done cycle, after every write has landed.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_FLUSH,
    ST_BASE,
    ST_DONE
  } lsm_state_e;

  localparam int unsigned WORD_SHIFT = 2;
endpackage

// File: rtl/lsm_addr.sv
module lsm_addr #(
  parameter int unsigned NREG    = 16,
  parameter int unsigned DW      = 32,
  parameter int unsigned LIMIT_W = 26,
  localparam int unsigned CNT_W  = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]  mask_i,
  input  logic [DW-1:0]    base_i,
  input  logic             up_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [DW-1:0]    start_o,
  output logic [DW-1:0]    final_o,
  output logic             aerr_o
);
  logic [DW-1:0] span;

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NREG; i++) cnt_o = cnt_o + CNT_W'(mask_i[i]);
  end

  assign span    = DW'(cnt_o) << lsm_pkg::WORD_SHIFT;
  assign final_o = up_i ? base_i + span : base_i - span;
  assign start_o = up_i ? base_i : base_i - span;
  assign aerr_o  = |start_o[DW-1:LIMIT_W];

  // R2: lowest address plus span always lands on the upper end
  always_comb begin
    assert_span_R2: assert (start_o + span == (up_i ? final_o : base_i));
  end
endmodule

// File: rtl/lsm_pick.sv
module lsm_pick #(
  parameter int unsigned NREG = 16,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  rem_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [NREG-1:0]  clr_o,
  output logic             last_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (rem_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign clr_o  = rem_i & (rem_i - NREG'(1));
  assign last_o = (clr_o == '0);

  // R1: the picked index is the lowest set bit
  always_comb begin
    if (rem_i != '0) begin
      assert_lowest_R1: assert (rem_i[idx_o] && ((rem_i & ((NREG'(1) << idx_o) - NREG'(1))) == '0));
    end
  end
endmodule

// File: rtl/lsm_pend.sv
module lsm_pend #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             drop_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    data_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [DW-1:0]    data_o
);
  // Holds the newest load until the next access proves it safe.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      data_o  <= '0;
    end else if (drop_i || clr_i) begin
      valid_o <= 1'b0;
    end else if (cap_i) begin
      valid_o <= 1'b1;
      idx_o   <= idx_i;
      data_o  <= data_i;
    end
  end

  assert_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> !valid_o);
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int unsigned NREG    = 16,
  parameter int unsigned DW      = 32,
  parameter int unsigned LIMIT_W = 26,
  localparam int unsigned IDX_W  = $clog2(NREG),
  localparam int unsigned CNT_W  = $clog2(NREG + 1),
  localparam int unsigned PC_IDX = NREG - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NREG-1:0]  mask_i,
  input  logic [IDX_W-1:0] base_idx_i,
  input  logic [DW-1:0]    base_addr_i,
  input  logic             up_i,
  input  logic             pre_i,
  input  logic             wb_i,
  input  logic             load_i,
  input  logic             s_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             exc_o,
  output logic             user_bank_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [DW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             mem_abort_i,
  output logic [IDX_W-1:0] rf_raddr_o,
  input  logic [DW-1:0]    rf_rdata_i,
  input  logic [DW-1:0]    pc_status_i,
  output logic             rf_we_o,
  output logic [IDX_W-1:0] rf_waddr_o,
  output logic [DW-1:0]    rf_wdata_o,
  output logic             psr_we_o
);
  import lsm_pkg::*;

  localparam logic [DW-1:0] WORD_B = DW'(1) << WORD_SHIFT;

  lsm_state_e       st_q;
  logic [NREG-1:0]  rem_q;
  logic [DW-1:0]    addr_q, final_q, init_q;
  logic [IDX_W-1:0] base_q;
  logic             up_q, pre_q, wb_q, load_q, s_q, has_pc_q;
  logic             first_q, aerr_q, sab_q, lab_q;

  logic [CNT_W-1:0] cnt_w;
  logic [DW-1:0]    start_w, final_w;
  logic             aerr_w;
  logic [IDX_W-1:0] cur_idx;
  logic [NREG-1:0]  rem_clr;
  logic             cur_last;

  logic             in_xfer, ld_ok, ld_drop, commit, base_wr;
  logic             pend_v;
  logic [IDX_W-1:0] pend_idx;
  logic [DW-1:0]    pend_data;

  lsm_addr #(.NREG(NREG), .DW(DW), .LIMIT_W(LIMIT_W)) u_addr (
    .mask_i (mask_i),
    .base_i (base_addr_i),
    .up_i   (up_i),
    .cnt_o  (cnt_w),
    .start_o(start_w),
    .final_o(final_w),
    .aerr_o (aerr_w)
  );

  lsm_pick #(.NREG(NREG)) u_pick (
    .rem_i (rem_q),
    .idx_o (cur_idx),
    .clr_o (rem_clr),
    .last_o(cur_last)
  );

  assign in_xfer = (st_q == ST_XFER);
  assign ld_ok   = in_xfer && load_q && !lab_q && !mem_abort_i;
  assign ld_drop = in_xfer && load_q && !lab_q && mem_abort_i;

  lsm_pend #(.IDX_W(IDX_W), .DW(DW)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (ld_ok),
    .drop_i (ld_drop),
    .clr_i  (st_q == ST_FLUSH),
    .idx_i  (cur_idx),
    .data_i (mem_rdata_i),
    .valid_o(pend_v),
    .idx_o  (pend_idx),
    .data_o (pend_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      rem_q    <= '0;
      addr_q   <= '0;
      final_q  <= '0;
      init_q   <= '0;
      base_q   <= '0;
      up_q     <= 1'b0;
      pre_q    <= 1'b0;
      wb_q     <= 1'b0;
      load_q   <= 1'b0;
      s_q      <= 1'b0;
      has_pc_q <= 1'b0;
      first_q  <= 1'b0;
      aerr_q   <= 1'b0;
      sab_q    <= 1'b0;
      lab_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          rem_q    <= mask_i;
          addr_q   <= start_w;
          final_q  <= final_w;
          init_q   <= base_addr_i;
          base_q   <= base_idx_i;
          up_q     <= up_i;
          pre_q    <= pre_i;
          wb_q     <= wb_i;
          load_q   <= load_i;
          s_q      <= s_i;
          has_pc_q <= mask_i[PC_IDX];
          first_q  <= 1'b1;
          aerr_q   <= aerr_w;
          sab_q    <= 1'b0;
          lab_q    <= 1'b0;
          st_q     <= (mask_i == '0) ? ST_FLUSH : ST_XFER;
        end
        ST_XFER: begin
          addr_q  <= addr_q + WORD_B;
          rem_q   <= rem_clr;
          first_q <= 1'b0;
          if (mem_req_o && mem_we_o && mem_abort_i) sab_q <= 1'b1;
          if (ld_drop) lab_q <= 1'b1;
          if (cur_last) st_q <= ST_FLUSH;
        end
        ST_FLUSH: st_q <= ST_BASE;
        ST_BASE:  st_q <= ST_DONE;
        ST_DONE:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  // memory side
  assign mem_req_o   = in_xfer && (load_q || !aerr_q);
  assign mem_we_o    = mem_req_o && !load_q;
  assign mem_addr_o  = (pre_q == up_q) ? addr_q + WORD_B : addr_q;
  assign rf_raddr_o  = cur_idx;
  assign mem_wdata_o = (cur_idx == IDX_W'(PC_IDX)) ? pc_status_i :
                       (cur_idx == base_q && wb_q && !first_q) ? final_q : rf_rdata_i;

  // register side: deferred commit, then base update
  assign commit  = (ld_ok && pend_v) || (st_q == ST_FLUSH && pend_v);
  assign base_wr = (st_q == ST_BASE) && (base_q != IDX_W'(PC_IDX)) && (wb_q || lab_q);

  always_comb begin
    rf_we_o    = commit || base_wr;
    rf_waddr_o = pend_idx;
    rf_wdata_o = pend_data;
    if (base_wr) begin
      rf_waddr_o = base_q;
      rf_wdata_o = wb_q ? final_q : init_q;
    end
  end

  assign psr_we_o = commit && load_q && s_q && (pend_idx == IDX_W'(PC_IDX));

  // status
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign exc_o       = done_o && (aerr_q || sab_q || lab_q);
  assign user_bank_o = (in_xfer || st_q == ST_FLUSH || st_q == ST_BASE) &&
                       s_q && (!load_q || !has_pc_q);

  assert_addr_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && in_xfer && $past(mem_req_o) && $past(st_q) == ST_XFER)
      |-> mem_addr_o == $past(mem_addr_o) + WORD_B);

  assert_abort_base_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lab_q && rf_we_o) |-> (rf_waddr_o == base_q && rf_wdata_o == (wb_q ? final_q : init_q)));

  assert_psr_pc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_we_o |-> (rf_we_o && rf_waddr_o == IDX_W'(PC_IDX) && s_q));

  assert_bank_released_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (done_o && !user_bank_o));

  assert_start_busy_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: tb/sim_lsm_seq.sv
module sim_lsm_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  localparam logic [31:0] PCST = 32'hC000_0ABC;

  // {mask16, bidx4, addr32, up, pre, wb, load, s, aben, abaddr32}
  localparam logic [89:0] VEC [NV] = '{
    {16'h000F, 4'd13, 32'h40, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},         // R1 R3
    {16'h2006, 4'd13, 32'h80, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},         // R2 R4
    {16'h0011, 4'd0,  32'h40, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},         // R4 first
    {16'h00F0, 4'd1,  32'h40, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0},         // R3
    {16'h0109, 4'd2,  32'hA0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},         // R2 R3
    {16'h0000, 4'd3,  32'h80, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},         // R5
    {16'h8003, 4'd4,  32'h40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},         // R6 R10
    {16'h8006, 4'd4,  32'h40, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0},         // R10
    {16'h0006, 4'd4,  32'h40, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0},         // R6
    {16'h001E, 4'd5,  32'h40, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h48},        // R7
    {16'h0070, 4'd6,  32'h40, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h48},        // R7
    {16'h00F0, 4'd7,  32'h40, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h48},        // R8
    {16'h0003, 4'd8,  32'h0400_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},  // R9
    {16'h0003, 4'd8,  32'h0400_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0},  // R9
    {16'h000C, 4'd9,  32'h40, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h40}         // R7
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic [3:0]  base_idx_i = '0;
  logic [31:0] base_addr_i = '0;
  logic        up_i = 1'b0, pre_i = 1'b0, wb_i = 1'b0, load_i = 1'b0, s_i = 1'b0;
  logic        busy_o, done_o, exc_o, user_bank_o;
  logic        mem_req_o, mem_we_o, mem_abort_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o;
  logic        rf_we_o, psr_we_o;

  logic [31:0] regs [16];
  logic [31:0] mem  [64];
  logic [31:0] psr_q;
  logic [31:0] eregs [16];
  logic [31:0] emem  [64];
  logic        init_req = 1'b0;
  logic        ab_en = 1'b0;
  logic [31:0] ab_addr = '0;
  int          nchecks = 0;
  int          nfail = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  lsm_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mask_i(mask_i),
    .base_idx_i(base_idx_i), .base_addr_i(base_addr_i), .up_i(up_i), .pre_i(pre_i),
    .wb_i(wb_i), .load_i(load_i), .s_i(s_i), .busy_o(busy_o), .done_o(done_o),
    .exc_o(exc_o), .user_bank_o(user_bank_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_abort_i(mem_abort_i), .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
    .pc_status_i(PCST), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .psr_we_o(psr_we_o)
  );

  function automatic logic [31:0] ireg(input int i);
    return 32'h1000_0000 + i * 32'h0101;
  endfunction
  function automatic logic [31:0] imem(input int j);
    return 32'hA000_0000 + j * 32'h10;
  endfunction

  assign mem_rdata_i = mem[mem_addr_o[7:2]];
  assign mem_abort_i = mem_req_o && ab_en && (mem_addr_o == ab_addr);
  assign rf_rdata_i  = regs[rf_raddr_o];

  always @(posedge clk_i) begin
    if (init_req) begin
      for (int i = 0; i < 16; i++) regs[i] <= (i == int'(base_idx_i)) ? base_addr_i : ireg(i);
      for (int j = 0; j < 64; j++) mem[j] <= imem(j);
      psr_q <= '0;
    end else begin
      if (rf_we_o) regs[rf_waddr_o] <= rf_wdata_o;
      if (psr_we_o) psr_q <= rf_wdata_o;
      if (mem_req_o && mem_we_o && !mem_abort_i) mem[mem_addr_o[7:2]] <= mem_wdata_o;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string vtag(input int v);
    case (v)
      0: return "R1 R3";
      1: return "R2 R4";
      2: return "R4";
      3: return "R3";
      4: return "R2";
      5: return "R5";
      6: return "R6 R10";
      7: return "R10";
      8: return "R6";
      9, 10, 14: return "R7";
      11: return "R8";
      default: return "R9";
    endcase
  endfunction

  // expected images computed from the requirements
  task automatic model(input logic [89:0] vv, output bit exc_e, output logic [31:0] psr_e, output int n);
    logic [15:0] m = vv[89:74];
    int          b = int'(vv[73:70]);
    logic [31:0] ba = vv[69:38];
    bit up = vv[37], pre = vv[36], wb = vv[35], ld = vv[34], s = vv[33], aben = vv[32];
    logic [31:0] aba = vv[31:0];
    logic [31:0] start, fin, addr, a, val, pold;
    bit aerr, sab = 0, lab = 0, pv = 0;
    int pi = 0, k = 0;
    n = 0;
    for (int i = 0; i < 16; i++) n += int'(m[i]);
    for (int i = 0; i < 16; i++) eregs[i] = (i == b) ? ba : ireg(i);
    for (int j = 0; j < 64; j++) emem[j] = imem(j);
    psr_e = '0;
    fin   = up ? ba + 32'(4 * n) : ba - 32'(4 * n);
    start = up ? ba : ba - 32'(4 * n);
    aerr  = (start >= 32'h0400_0000);
    addr  = start;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        a = (pre == up) ? addr + 4 : addr;
        addr += 4;
        if (!ld) begin
          val = (i == 15) ? PCST : (i == b && wb && k > 0) ? fin : eregs[i];
          if (!aerr) begin
            if (aben && a == aba) sab = 1;
            else emem[a[7:2]] = val;
          end
        end else if (!lab) begin
          if (aben && a == aba) begin
            if (pv) eregs[pi] = pold;
            lab = 1;
            pv = 0;
          end else begin
            pold = eregs[i];
            eregs[i] = emem[a[7:2]];
            pi = i;
            pv = 1;
            if (i == 15 && s) psr_e = emem[a[7:2]];
          end
        end
        k++;
      end
    end
    if (b != 15 && (wb || lab)) eregs[b] = wb ? fin : ba;
    exc_e = aerr || sab || lab;
  endtask

  task automatic run_vec(input int v);
    logic [89:0] vv = VEC[v];
    bit exc_e, ub_e, ub_seen;
    logic [31:0] psr_e;
    int n, cnt, bad, first_bad;
    string tg = vtag(v);
    model(vv, exc_e, psr_e, n);
    @(negedge clk_i);
    mask_i = vv[89:74]; base_idx_i = vv[73:70]; base_addr_i = vv[69:38];
    up_i = vv[37]; pre_i = vv[36]; wb_i = vv[35]; load_i = vv[34]; s_i = vv[33];
    ab_en = vv[32]; ab_addr = vv[31:0];
    init_req = 1'b1;
    @(negedge clk_i);
    init_req = 1'b0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    ub_seen = user_bank_o;
    cnt = 1;
    while (!done_o && cnt < 100) begin
      @(negedge clk_i);
      cnt++;
    end
    ub_e = s_i && (!load_i || !mask_i[15]);
    chk(cnt == n + 3, {tg, " R13 latency"}, 32'(cnt), 32'(n + 3));
    chk(exc_o == exc_e, {tg, " R8 R9 exc"}, 32'(exc_o), 32'(exc_e));
    chk(ub_seen == ub_e, {tg, " R6 user bank"}, 32'(ub_seen), 32'(ub_e));
    chk(!user_bank_o, {tg, " R11 bank at done"}, 32'(user_bank_o), 32'h0);
    chk(psr_q == psr_e, {tg, " R10 status"}, psr_q, psr_e);
    bad = 0; first_bad = 0;
    for (int i = 15; i >= 0; i--) if (regs[i] !== eregs[i]) begin bad++; first_bad = i; end
    chk(bad == 0, {tg, " regs"}, regs[first_bad], eregs[first_bad]);
    bad = 0; first_bad = 0;
    for (int j = 63; j >= 0; j--) if (mem[j] !== emem[j]) begin bad++; first_bad = j; end
    chk(bad == 0, {tg, " mem"}, mem[first_bad], emem[first_bad]);
    @(negedge clk_i);
    chk(!busy_o && !done_o, {tg, " R13 single done"}, 32'(done_o), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12: reset state
    chk(!busy_o && !done_o && !mem_req_o && !rf_we_o && !user_bank_o, "R12 in reset",
        {27'h0, busy_o, done_o, mem_req_o, rf_we_o, user_bank_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o && !user_bank_o, "R12 after reset",
        {28'h0, busy_o, done_o, mem_req_o, user_bank_o}, 32'h0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R12: reset in the middle of a long transfer
    @(negedge clk_i);
    mask_i = 16'h7FFF; load_i = 1'b0; s_i = 1'b1; up_i = 1'b1; pre_i = 1'b0;
    base_addr_i = 32'h40; ab_en = 1'b0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(busy_o && mem_req_o, "R12 mid transfer active", {30'h0, busy_o, mem_req_o}, 32'h3);
    rst_ni = 1'b0;
    #1;
    chk(!busy_o && !mem_req_o && !rf_we_o && !user_bank_o, "R12 mid reset",
        {28'h0, busy_o, mem_req_o, rf_we_o, user_bank_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R12 idle after reset", {30'h0, busy_o, done_o}, 32'h0);

    // back to normal operation after reset
    run_vec(0);

    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule